// File: doc/BRIEF.md
# Dual-Address Transparent Register File

This block is a small storage array of four words, each four bits wide. It has a write side and a read side with their own address and enable pins, so one word can be written while a different word is read in the same instant. Storage is level-sensitive. While the active-low write strobe is low, the selected word is open and follows the data input. When the strobe goes high, the word keeps the last value it had.

The read side uses an active-low read enable. When that enable is low, the word chosen by the read address appears uninverted on the data outputs, and the output-enable flag is set. When the enable is high, the flag is cleared, the data vector is parked at zero, and the bus net floats. Several files can therefore share one bus to extend the word count, provided their read enables never overlap.

An asynchronous active-low clear empties every word. The clear takes priority over any write.

Top module: `rf4x4_tristate`

## Requirements
- R1: The array holds four 4-bit words. Word k is selected when the 2-bit address equals k, and each word keeps its own value independently of the others.
- R2: A write to one address and a read of a different address can take place at the same time without disturbing each other.
- R3: While `we_n` is 0 and `rst_n` is 1, the word at `wr_addr` takes the value of `wr_data`.
- R4: While `we_n` stays 0, any change on `wr_data` appears in the addressed word without waiting for any edge.
- R5: While `we_n` is 1, `wr_data` and `wr_addr` have no effect, and every word keeps its value.
- R6: While `re_n` is 0, `q_oe` is 1 and `q_data` shows the word at `rd_addr`, uninverted.
- R7: While `re_n` is 1, `q_oe` is 0, `q_data` is 4'b0000, and `q_bus` is high impedance.
- R8: If `rd_addr` equals `wr_addr` while both enables are low, `q_data` shows `wr_data` directly.
- R9: While `rst_n` is 0, every word reads as 4'b0000, even when a write is requested at the same time.
- R10: While `q_oe` is 1, the tri-state net `q_bus` carries the same value as `q_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of all words |
| we_n | input | 1 | Active-low write strobe; the word stays open while low |
| wr_addr | input | 2 | Word selected for writing |
| wr_data | input | 4 | Data written into the open word |
| re_n | input | 1 | Active-low read enable |
| rd_addr | input | 2 | Word selected for reading |
| q_data | output | 4 | Read data; zero while reads are disabled |
| q_oe | output | 1 | High while the outputs drive the bus |
| q_bus | output | 4 | Tri-state form of the read data |

## Verification
A word latched at the wrong address, or left open after `we_n` rises, shows up at the ports only on the next read of the affected word. For this reason the vectors read back every word that was written and every word that should have stayed unchanged. A broken decode or a broken read mux shows up immediately, in the same settled interval, because the read path contains no register. Write-through, and the clear taking priority over a write, are each checked in the interval in which they occur.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_WORDS  = 4;
  localparam int unsigned RF_WIDTH  = 4;
  localparam int unsigned RF_ADDR_W = $clog2(RF_WORDS);
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned WORDS  = rf_pkg::RF_WORDS,
  localparam int unsigned ADDR_W = $clog2(WORDS)
) (
  input  logic              we_n,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [WORDS-1:0]  strobe
);
  for (genvar k = 0; k < WORDS; k++) begin : g_dec
    assign strobe[k] = !we_n && (wr_addr == ADDR_W'(k));
  end

  always_comb begin
    p_one_strobe_r5: assert ($onehot0(strobe));
    if (we_n) p_idle_no_strobe_r5: assert (strobe == '0);
  end
endmodule

// File: rtl/rf_word_store.sv
module rf_word_store #(
  parameter int unsigned WORDS  = rf_pkg::RF_WORDS,
  parameter int unsigned WIDTH  = rf_pkg::RF_WIDTH,
  localparam int unsigned ADDR_W = $clog2(WORDS)
) (
  input  logic                  rst_n,
  input  logic                  we_n,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [WORDS-1:0]      strobe,
  input  logic [WIDTH-1:0]      wr_data,
  output logic [WIDTH-1:0]      words [WORDS]
);
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_latch begin
      if (!rst_n)         words[k] <= '0;
      else if (strobe[k]) words[k] <= wr_data;
    end
  end

  always_comb begin
    if (rst_n && !we_n)
      p_open_word_follows_r3: assert (words[wr_addr] == wr_data);
  end
endmodule

// File: rtl/rf_rd_select.sv
module rf_rd_select #(
  parameter int unsigned WORDS  = rf_pkg::RF_WORDS,
  parameter int unsigned WIDTH  = rf_pkg::RF_WIDTH,
  localparam int unsigned ADDR_W = $clog2(WORDS)
) (
  input  logic [WIDTH-1:0]  words [WORDS],
  input  logic              re_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  q_data,
  output logic              q_oe
);
  always_comb begin
    q_oe   = !re_n;
    q_data = '0;
    if (!re_n) q_data = words[rd_addr];
  end

  always_comb begin
    if (!q_oe) p_parked_when_off_r7: assert (q_data == '0);
  end
endmodule

// File: rtl/rf4x4_tristate.sv
module rf4x4_tristate #(
  parameter int unsigned WORDS  = rf_pkg::RF_WORDS,
  parameter int unsigned WIDTH  = rf_pkg::RF_WIDTH,
  localparam int unsigned ADDR_W = $clog2(WORDS)
) (
  input  logic              rst_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              re_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  q_data,
  output logic              q_oe,
  output wire  [WIDTH-1:0]  q_bus
);
  logic [WORDS-1:0] strobe;
  logic [WIDTH-1:0] words [WORDS];

  rf_wr_decode #(.WORDS(WORDS)) u_dec (
    .we_n   (we_n),
    .wr_addr(wr_addr),
    .strobe (strobe)
  );

  rf_word_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .rst_n  (rst_n),
    .we_n   (we_n),
    .wr_addr(wr_addr),
    .strobe (strobe),
    .wr_data(wr_data),
    .words  (words)
  );

  rf_rd_select #(.WORDS(WORDS), .WIDTH(WIDTH)) u_rd (
    .words  (words),
    .re_n   (re_n),
    .rd_addr(rd_addr),
    .q_data (q_data),
    .q_oe   (q_oe)
  );

  assign q_bus = q_oe ? q_data : 'z;

  always_comb begin
    if (rst_n && !we_n && !re_n && (rd_addr == wr_addr))
      p_write_through_r8: assert (q_data == wr_data);
    if (!rst_n && !re_n)
      p_clear_reads_zero_r9: assert (q_data == '0);
  end
endmodule

// File: tb/test_rf4x4_tristate.sv
module test_rf4x4_tristate;
  typedef struct packed {
    logic       rst_n;
    logic       we_n;
    logic [1:0] wa;
    logic [3:0] wd;
    logic       re_n;
    logic [1:0] ra;
    logic       exp_oe;
    logic [3:0] exp_q;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 2'd0, 4'h0, 1'b0, 2'd0, 1'b1, 4'h0, 4'd9},  // R9 cleared
    '{1'b1, 1'b0, 2'd0, 4'h5, 1'b0, 2'd1, 1'b1, 4'h0, 4'd2},  // R2 write w0, read w1
    '{1'b1, 1'b0, 2'd1, 4'hA, 1'b0, 2'd0, 1'b1, 4'h5, 4'd3},  // R3 w0 kept 5
    '{1'b1, 1'b0, 2'd2, 4'h3, 1'b0, 2'd2, 1'b1, 4'h3, 4'd8},  // R8 write-through
    '{1'b1, 1'b0, 2'd2, 4'hC, 1'b0, 2'd2, 1'b1, 4'hC, 4'd4},  // R4 follow data
    '{1'b1, 1'b1, 2'd2, 4'hF, 1'b0, 2'd2, 1'b1, 4'hC, 4'd5},  // R5 data ignored
    '{1'b1, 1'b1, 2'd3, 4'h9, 1'b0, 2'd3, 1'b1, 4'h0, 4'd5},  // R5 addr ignored
    '{1'b1, 1'b0, 2'd3, 4'h6, 1'b1, 2'd3, 1'b0, 4'h0, 4'd7},  // R7 disabled
    '{1'b1, 1'b1, 2'd0, 4'h0, 1'b0, 2'd3, 1'b1, 4'h6, 4'd6},  // R6 read w3
    '{1'b1, 1'b1, 2'd0, 4'h0, 1'b0, 2'd1, 1'b1, 4'hA, 4'd1},  // R1 w1 kept
    '{1'b1, 1'b1, 2'd0, 4'h0, 1'b1, 2'd1, 1'b0, 4'h0, 4'd7},  // R7 disabled again
    '{1'b0, 1'b0, 2'd0, 4'h7, 1'b0, 2'd0, 1'b1, 4'h0, 4'd9},  // R9 clear beats write
    '{1'b1, 1'b1, 2'd0, 4'h7, 1'b0, 2'd0, 1'b1, 4'h0, 4'd9}   // R9 still zero
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we_n = 1'b1;
  logic [1:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       re_n = 1'b1;
  logic [1:0] rd_addr = '0;
  logic [3:0] q_data;
  logic       q_oe;
  wire  [3:0] q_bus;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  rf4x4_tristate i_rf4x4_tristate (
    .rst_n(rst_n), .we_n(we_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .re_n(re_n), .rd_addr(rd_addr), .q_data(q_data), .q_oe(q_oe), .q_bus(q_bus)
  );

  task automatic check(input int req, input logic oe_e, input logic [3:0] q_e);
    n_cmp++;
    if (q_oe !== oe_e || q_data !== q_e) begin
      n_bad++;
      $display("FAIL R%0d: oe=%b q=%h expected oe=%b q=%h", req, q_oe, q_data, oe_e, q_e);
    end
    if (oe_e) begin
      n_cmp++;
      if (q_bus !== q_e) begin
        n_bad++;
        $display("FAIL R10: bus=%h expected %h", q_bus, q_e);
      end
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    rst_n = v.rst_n; we_n = v.we_n; wr_addr = v.wa; wr_data = v.wd;
    re_n = v.re_n; rd_addr = v.ra;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    check(9, 1'b0, 4'h0);  // R9 and R7 reset state, reads off
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check(int'(VECS[i].req), VECS[i].exp_oe, VECS[i].exp_q);
    end
    // R4: data changes mid-strobe, word follows without an edge
    apply('{1'b1, 1'b0, 2'd1, 4'h2, 1'b0, 2'd1, 1'b1, 4'h2, 4'd4});
    check(4, 1'b1, 4'h2);
    #1 wr_data = 4'hE;
    #1 check(4, 1'b1, 4'hE);
    // R1: every word readable, others undisturbed
    apply('{1'b1, 1'b1, 2'd0, 4'h0, 1'b0, 2'd1, 1'b1, 4'hE, 4'd1});
    check(1, 1'b1, 4'hE);
    apply('{1'b1, 1'b0, 2'd2, 4'h1, 1'b1, 2'd0, 1'b0, 4'h0, 4'd1});
    apply('{1'b1, 1'b1, 2'd0, 4'h0, 1'b0, 2'd2, 1'b1, 4'h1, 4'd1});
    check(1, 1'b1, 4'h1);
    apply('{1'b1, 1'b1, 2'd0, 4'h0, 1'b0, 2'd1, 1'b1, 4'hE, 4'd1});
    check(1, 1'b1, 4'hE);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule